// File: doc/BRIEF.md
# Descriptor ring DMA controller

This block is the device-side engine that walks two rings of descriptors held in shared memory: one ring for frames going out and one for frames coming in. A descriptor is four 32-bit words at consecutive addresses: status, control, buffer address and a next-pointer word. The engine reads and writes these words through a plain single-word memory port. The host hands a descriptor to the engine by setting its ownership bit. The engine hands it back by clearing that bit in a status write-back. Moving payload bytes is done elsewhere: the transmit side only announces each segment (buffer address, length, position flags) to a downstream sink and collects a pass/fail result. The receive side only offers a buffer address to an upstream source and records the length and error outcome of each frame.

Each direction has its own run level and ring base. Transmit sleeps when it meets a descriptor it does not own and wakes on a poll strobe. Receive sleeps in the same situation and retries when a frame is waiting. While it retries it holds the frame off and flags an overflow. Both engines share the memory port through a fixed-priority arbiter, and receive wins when both request.

Top module: `desc_ring_dma`

## Requirements
- R1: While rst_ni is low and after its release, both process-state outputs read 0 (stopped), no memory request is made, no segment is offered and no frame is accepted.
- R2: For each transmit descriptor whose status bit 31 is set, the engine offers one segment with the buffer-address word, length = control bits 10:0, first = control bit 29, last = control bit 30 and setup = control bit 27. The offer holds steady until the sink signals done.
- R3: After the sink's done, the engine writes the status word exactly once: bit 31 is cleared, bit 15 equals the sink's error flag, and all other bits are zero.
- R4: On a transmit descriptor with status bit 31 clear, the transmit state becomes 2 (suspended) and the engine makes no memory access until a poll strobe. The cycle after the poll strobe is sampled, it requests a read of that same descriptor's status word.
- R5: A descriptor with control bit 25 set is followed by the ring base. Any other descriptor is followed by the descriptor 16 bytes further on. This holds in both directions.
- R6: With an owned receive descriptor fetched, the engine raises rx_frm_ready_o and presents its buffer address. An accepted frame leads to one status write: frame length in bits 29:16, bit 8 set, bit 15 equal to the frame error flag, and bit 31 cleared.
- R7: When the next receive descriptor is not owned, the receive state is 3 (suspended) and rx_frm_ready_o stays low. While a frame is pending, rx_ovf_o is high and the status word is re-read until ownership returns.
- R8: The transmit and receive sides start and stop independently through their run inputs. A stop takes effect only between descriptors or while suspended. A start from the stopped state fetches from the ring base in the following cycle.
- R9: At most one engine is granted the memory port per cycle, and receive wins a conflict. Read data is taken one cycle after the granted request.
- R10: A poll strobe while transmit is stopped has no effect: the state stays 0 and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_base_i | input | AW | Transmit ring base byte address |
| rx_base_i | input | AW | Receive ring base byte address |
| tx_run_i | input | 1 | Transmit process run level |
| rx_run_i | input | 1 | Receive process run level |
| tx_poll_i | input | 1 | Transmit poll-demand strobe |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address (word aligned) |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, one cycle after request |
| tx_seg_valid_o | output | 1 | Segment offered to sink |
| tx_seg_addr_o | output | AW | Segment buffer address |
| tx_seg_len_o | output | LEN_W | Segment length in bytes |
| tx_seg_first_o | output | 1 | First segment of frame |
| tx_seg_last_o | output | 1 | Last segment of frame |
| tx_seg_setup_o | output | 1 | Segment is an address-filter setup frame |
| tx_seg_done_i | input | 1 | Sink finished the segment |
| tx_seg_err_i | input | 1 | Sink reports failure, sampled with done |
| rx_frm_valid_i | input | 1 | A received frame is waiting |
| rx_frm_len_i | input | RX_LEN_W | Frame length including CRC |
| rx_frm_err_i | input | 1 | Frame had an error |
| rx_frm_ready_o | output | 1 | Buffer available, frame accepted when valid |
| rx_buf_addr_o | output | AW | Buffer address for the accepted frame |
| rx_ovf_o | output | 1 | Frame pending with no owned descriptor |
| tx_state_o | output | 2 | Transmit state: 0 stopped, 1 running, 2 suspended |
| rx_state_o | output | 2 | Receive state: 0 stopped, 1 running, 3 suspended |

## Verification
Each of the three descriptor words costs one request cycle and one data cycle. An uncontended transmit segment therefore appears six cycles after its status request. The write-back request follows one cycle after done, and the freed receive status lands one cycle after acceptance. The poll and start reactions are due exactly one cycle after the strobe or run level is sampled. The bench checks those at the very next falling edge. Results with longer or contention-dependent latency are checked after waiting on the handshake or the state output with a bounded loop. All inputs are driven and all outputs sampled on falling edges.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int OWN_BIT      = 31;
  localparam int ES_BIT       = 15;
  localparam int LS_BIT       = 8;
  localparam int EOR_BIT      = 25;
  localparam int TX_LAST_BIT  = 30;
  localparam int TX_FIRST_BIT = 29;
  localparam int TX_SETUP_BIT = 27;
  localparam int RX_LEN_LSB   = 16;
  localparam int DESC_BYTES   = 16;

  typedef enum logic [1:0] {
    PS_STOPPED   = 2'd0,
    PS_RUNNING   = 2'd1,
    PS_TX_SUSP   = 2'd2,
    PS_RX_SUSP   = 2'd3
  } proc_state_e;
endpackage

// File: rtl/desc_mem_arb.sv
module desc_mem_arb #(
  parameter int N  = 2,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0]         we_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  input  logic [N-1:0][DW-1:0] wdata_i,
  output logic [N-1:0]         gnt_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o
);
  // lowest index wins: scan from the top so lower indices override
  always_comb begin
    gnt_o       = '0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o       = '0;
        gnt_o[i]    = 1'b1;
        mem_req_o   = 1'b1;
        mem_we_o    = we_i[i];
        mem_addr_o  = addr_i[i];
        mem_wdata_o = wdata_i[i];
      end
    end
  end
endmodule

// File: rtl/desc_tx_eng.sv
module desc_tx_eng
  import desc_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             poll_i,
  input  logic [AW-1:0]    base_i,
  output logic             mreq_o,
  output logic             mwe_o,
  output logic [AW-1:0]    maddr_o,
  output logic [DW-1:0]    mwdata_o,
  input  logic             mgnt_i,
  input  logic [DW-1:0]    mrdata_i,
  output logic             seg_valid_o,
  output logic [AW-1:0]    seg_addr_o,
  output logic [LEN_W-1:0] seg_len_o,
  output logic             seg_first_o,
  output logic             seg_last_o,
  output logic             seg_setup_o,
  input  logic             seg_done_i,
  input  logic             seg_err_i,
  output logic [1:0]       state_o
);
  typedef enum logic [2:0] {T_STOP, T_RD, T_WT, T_XFER, T_WB, T_SUSP} tx_st_e;

  tx_st_e           st_q;
  logic [AW-1:0]    cur_q, buf_q, nxt;
  logic [1:0]       widx_q;
  logic [LEN_W-1:0] len_q;
  logic             first_q, last_q, setup_q, eor_q, err_q;

  assign nxt = eor_q ? base_i : cur_q + AW'(DESC_BYTES);

  always_comb begin
    mreq_o   = (st_q == T_RD) || (st_q == T_WB);
    mwe_o    = (st_q == T_WB);
    maddr_o  = (st_q == T_WB) ? cur_q : cur_q + AW'({widx_q, 2'b00});
    mwdata_o = '0;
    mwdata_o[ES_BIT] = err_q;   // ownership bit left clear
  end

  assign seg_valid_o = (st_q == T_XFER);
  assign seg_addr_o  = buf_q;
  assign seg_len_o   = len_q;
  assign seg_first_o = first_q;
  assign seg_last_o  = last_q;
  assign seg_setup_o = setup_q;

  always_comb begin
    case (st_q)
      T_STOP:  state_o = PS_STOPPED;
      T_SUSP:  state_o = PS_TX_SUSP;
      default: state_o = PS_RUNNING;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_STOP;
      cur_q   <= '0;
      buf_q   <= '0;
      widx_q  <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      setup_q <= 1'b0;
      eor_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        T_STOP: if (run_i) begin
          st_q   <= T_RD;
          cur_q  <= base_i;
          widx_q <= '0;
        end
        T_RD: begin
          if (!run_i && widx_q == 2'd0) st_q <= T_STOP;
          else if (mgnt_i)              st_q <= T_WT;
        end
        T_WT: begin
          case (widx_q)
            2'd0: begin
              if (!mrdata_i[OWN_BIT]) st_q <= T_SUSP;
              else begin
                widx_q <= 2'd1;
                st_q   <= T_RD;
              end
            end
            2'd1: begin
              len_q   <= mrdata_i[LEN_W-1:0];
              first_q <= mrdata_i[TX_FIRST_BIT];
              last_q  <= mrdata_i[TX_LAST_BIT];
              setup_q <= mrdata_i[TX_SETUP_BIT];
              eor_q   <= mrdata_i[EOR_BIT];
              widx_q  <= 2'd2;
              st_q    <= T_RD;
            end
            default: begin
              buf_q <= mrdata_i[AW-1:0];
              st_q  <= T_XFER;
            end
          endcase
        end
        T_XFER: if (seg_done_i) begin
          err_q <= seg_err_i;
          st_q  <= T_WB;
        end
        T_WB: if (mgnt_i) begin
          cur_q  <= nxt;
          widx_q <= '0;
          st_q   <= T_RD;
        end
        T_SUSP: begin
          if (!run_i) st_q <= T_STOP;
          else if (poll_i) begin
            widx_q <= '0;
            st_q   <= T_RD;
          end
        end
        default: st_q <= T_STOP;
      endcase
    end
  end
endmodule

// File: rtl/desc_rx_eng.sv
module desc_rx_eng
  import desc_dma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int RX_LEN_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [AW-1:0]       base_i,
  output logic                mreq_o,
  output logic                mwe_o,
  output logic [AW-1:0]       maddr_o,
  output logic [DW-1:0]       mwdata_o,
  input  logic                mgnt_i,
  input  logic [DW-1:0]       mrdata_i,
  input  logic                frm_valid_i,
  input  logic [RX_LEN_W-1:0] frm_len_i,
  input  logic                frm_err_i,
  output logic                frm_ready_o,
  output logic [AW-1:0]       buf_addr_o,
  output logic                ovf_o,
  output logic [1:0]          state_o
);
  typedef enum logic [2:0] {R_STOP, R_RD, R_WT, R_RDY, R_WB, R_SUSP} rx_st_e;

  rx_st_e              st_q;
  logic [AW-1:0]       cur_q, buf_q, nxt;
  logic [1:0]          widx_q;
  logic [RX_LEN_W-1:0] len_q;
  logic                eor_q, err_q;

  assign nxt = eor_q ? base_i : cur_q + AW'(DESC_BYTES);

  always_comb begin
    mreq_o   = (st_q == R_RD) || (st_q == R_WB);
    mwe_o    = (st_q == R_WB);
    maddr_o  = (st_q == R_WB) ? cur_q : cur_q + AW'({widx_q, 2'b00});
    mwdata_o = '0;
    mwdata_o[RX_LEN_LSB +: RX_LEN_W] = len_q;
    mwdata_o[ES_BIT] = err_q;
    mwdata_o[LS_BIT] = 1'b1;
  end

  assign frm_ready_o = (st_q == R_RDY);
  assign buf_addr_o  = buf_q;
  assign ovf_o       = (st_q == R_SUSP) && frm_valid_i;

  always_comb begin
    case (st_q)
      R_STOP:  state_o = PS_STOPPED;
      R_SUSP:  state_o = PS_RX_SUSP;
      default: state_o = PS_RUNNING;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_STOP;
      cur_q  <= '0;
      buf_q  <= '0;
      widx_q <= '0;
      len_q  <= '0;
      eor_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        R_STOP: if (run_i) begin
          st_q   <= R_RD;
          cur_q  <= base_i;
          widx_q <= '0;
        end
        R_RD: begin
          if (!run_i && widx_q == 2'd0) st_q <= R_STOP;
          else if (mgnt_i)              st_q <= R_WT;
        end
        R_WT: begin
          case (widx_q)
            2'd0: begin
              if (!mrdata_i[OWN_BIT]) st_q <= R_SUSP;
              else begin
                widx_q <= 2'd1;
                st_q   <= R_RD;
              end
            end
            2'd1: begin
              eor_q  <= mrdata_i[EOR_BIT];
              widx_q <= 2'd2;
              st_q   <= R_RD;
            end
            default: begin
              buf_q <= mrdata_i[AW-1:0];
              st_q  <= R_RDY;
            end
          endcase
        end
        R_RDY: begin
          if (frm_valid_i) begin
            len_q <= frm_len_i;
            err_q <= frm_err_i;
            st_q  <= R_WB;
          end else if (!run_i) st_q <= R_STOP;
        end
        R_WB: if (mgnt_i) begin
          cur_q  <= nxt;
          widx_q <= '0;
          st_q   <= R_RD;
        end
        R_SUSP: begin
          if (!run_i) st_q <= R_STOP;
          else if (frm_valid_i) begin
            widx_q <= '0;
            st_q   <= R_RD;
          end
        end
        default: st_q <= R_STOP;
      endcase
    end
  end
endmodule

// File: rtl/desc_ring_dma.sv
module desc_ring_dma #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LEN_W    = 11,
  parameter int RX_LEN_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       tx_base_i,
  input  logic [AW-1:0]       rx_base_i,
  input  logic                tx_run_i,
  input  logic                rx_run_i,
  input  logic                tx_poll_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW-1:0]       mem_wdata_o,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                tx_seg_valid_o,
  output logic [AW-1:0]       tx_seg_addr_o,
  output logic [LEN_W-1:0]    tx_seg_len_o,
  output logic                tx_seg_first_o,
  output logic                tx_seg_last_o,
  output logic                tx_seg_setup_o,
  input  logic                tx_seg_done_i,
  input  logic                tx_seg_err_i,
  input  logic                rx_frm_valid_i,
  input  logic [RX_LEN_W-1:0] rx_frm_len_i,
  input  logic                rx_frm_err_i,
  output logic                rx_frm_ready_o,
  output logic [AW-1:0]       rx_buf_addr_o,
  output logic                rx_ovf_o,
  output logic [1:0]          tx_state_o,
  output logic [1:0]          rx_state_o
);
  localparam int NPORT = 2;
  localparam int P_RX  = 0;  // higher priority
  localparam int P_TX  = 1;

  logic [NPORT-1:0]         req_v, we_v, gnt_v;
  logic [NPORT-1:0][AW-1:0] addr_v;
  logic [NPORT-1:0][DW-1:0] wdata_v;

  desc_mem_arb #(.N(NPORT), .AW(AW), .DW(DW)) u_arb (
    .req_i      (req_v),
    .we_i       (we_v),
    .addr_i     (addr_v),
    .wdata_i    (wdata_v),
    .gnt_o      (gnt_v),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  desc_tx_eng #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (tx_run_i),
    .poll_i     (tx_poll_i),
    .base_i     (tx_base_i),
    .mreq_o     (req_v[P_TX]),
    .mwe_o      (we_v[P_TX]),
    .maddr_o    (addr_v[P_TX]),
    .mwdata_o   (wdata_v[P_TX]),
    .mgnt_i     (gnt_v[P_TX]),
    .mrdata_i   (mem_rdata_i),
    .seg_valid_o(tx_seg_valid_o),
    .seg_addr_o (tx_seg_addr_o),
    .seg_len_o  (tx_seg_len_o),
    .seg_first_o(tx_seg_first_o),
    .seg_last_o (tx_seg_last_o),
    .seg_setup_o(tx_seg_setup_o),
    .seg_done_i (tx_seg_done_i),
    .seg_err_i  (tx_seg_err_i),
    .state_o    (tx_state_o)
  );

  desc_rx_eng #(.AW(AW), .DW(DW), .RX_LEN_W(RX_LEN_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (rx_run_i),
    .base_i     (rx_base_i),
    .mreq_o     (req_v[P_RX]),
    .mwe_o      (we_v[P_RX]),
    .maddr_o    (addr_v[P_RX]),
    .mwdata_o   (wdata_v[P_RX]),
    .mgnt_i     (gnt_v[P_RX]),
    .mrdata_i   (mem_rdata_i),
    .frm_valid_i(rx_frm_valid_i),
    .frm_len_i  (rx_frm_len_i),
    .frm_err_i  (rx_frm_err_i),
    .frm_ready_o(rx_frm_ready_o),
    .buf_addr_o (rx_buf_addr_o),
    .ovf_o      (rx_ovf_o),
    .state_o    (rx_state_o)
  );
endmodule

// File: rtl/desc_ring_dma_chk.sv
module desc_ring_dma_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_poll_i,
  input logic             tx_run_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic             tx_seg_valid_o,
  input logic [AW-1:0]    tx_seg_addr_o,
  input logic [LEN_W-1:0] tx_seg_len_o,
  input logic             tx_seg_done_i,
  input logic             rx_frm_ready_o,
  input logic             rx_ovf_o,
  input logic [1:0]       tx_state_o,
  input logic [1:0]       rx_state_o,
  input logic [1:0]       req_v,
  input logic [1:0]       we_v,
  input logic [1:0]       gnt_v,
  input logic [1:0][DW-1:0] wdata_v
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (tx_state_o == 2'd0 && rx_state_o == 2'd0 && !mem_req_o);
    end
  end

  p_seg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_seg_valid_o && !tx_seg_done_i) |=>
      (tx_seg_valid_o && $stable(tx_seg_addr_o) && $stable(tx_seg_len_o)));

  p_wb_own_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[31]);

  p_susp_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_state_o == 2'd2 && !tx_poll_i) |=> !req_v[1]);

  p_rx_last_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_v[0] && we_v[0]) |-> wdata_v[0][8]);

  p_ovf_no_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |-> (!rx_frm_ready_o && rx_state_o == 2'd3));

  p_stop_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_state_o == 2'd0 && !tx_run_i) |=> (tx_state_o == 2'd0));

  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_v));

  p_rx_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_v[0] |-> gnt_v[0]);

  p_poll_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_state_o == 2'd0 && !tx_run_i) |=> !req_v[1]);
endmodule

bind desc_ring_dma desc_ring_dma_chk #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_poll_i     (tx_poll_i),
  .tx_run_i      (tx_run_i),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_wdata_o   (mem_wdata_o),
  .tx_seg_valid_o(tx_seg_valid_o),
  .tx_seg_addr_o (tx_seg_addr_o),
  .tx_seg_len_o  (tx_seg_len_o),
  .tx_seg_done_i (tx_seg_done_i),
  .rx_frm_ready_o(rx_frm_ready_o),
  .rx_ovf_o      (rx_ovf_o),
  .tx_state_o    (tx_state_o),
  .rx_state_o    (rx_state_o),
  .req_v         (req_v),
  .we_v          (we_v),
  .gnt_v         (gnt_v),
  .wdata_v       (wdata_v)
);

// File: tb/desc_ring_dma_tb.sv
module desc_ring_dma_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tx_run = 0, rx_run = 0, tx_poll = 0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, rdata;
  logic        tx_seg_valid_o, tx_seg_first_o, tx_seg_last_o, tx_seg_setup_o;
  logic [31:0] tx_seg_addr_o;
  logic [10:0] tx_seg_len_o;
  logic        tx_done = 0, tx_err = 0;
  logic        rx_valid = 0, rx_err = 0;
  logic [13:0] rx_len = '0;
  logic        rx_frm_ready_o, rx_ovf_o;
  logic [31:0] rx_buf_addr_o;
  logic [1:0]  tx_state_o, rx_state_o;

  localparam logic [31:0] TXB = 32'h0000_0000;
  localparam logic [31:0] RXB = 32'h0000_0100;  // word 64

  always #4 clk = ~clk;

  desc_ring_dma u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_base_i(TXB), .rx_base_i(RXB),
    .tx_run_i(tx_run), .rx_run_i(rx_run), .tx_poll_i(tx_poll),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rdata),
    .tx_seg_valid_o(tx_seg_valid_o), .tx_seg_addr_o(tx_seg_addr_o),
    .tx_seg_len_o(tx_seg_len_o), .tx_seg_first_o(tx_seg_first_o),
    .tx_seg_last_o(tx_seg_last_o), .tx_seg_setup_o(tx_seg_setup_o),
    .tx_seg_done_i(tx_done), .tx_seg_err_i(tx_err),
    .rx_frm_valid_i(rx_valid), .rx_frm_len_i(rx_len), .rx_frm_err_i(rx_err),
    .rx_frm_ready_o(rx_frm_ready_o), .rx_buf_addr_o(rx_buf_addr_o),
    .rx_ovf_o(rx_ovf_o), .tx_state_o(tx_state_o), .rx_state_o(rx_state_o)
  );

  // shared memory model, one-cycle read latency
  logic [31:0] mem [0:255];
  logic        h_we = 0;
  logic [7:0]  h_idx = '0;
  logic [31:0] h_dat = '0;
  int          wr_cnt = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      rdata  <= '0;
      wr_cnt <= 0;
    end else begin
      if (h_we) mem[h_idx] <= h_dat;
      if (mem_req_o) begin
        if (mem_we_o) begin
          mem[mem_addr_o[9:2]] <= mem_wdata_o;
          wr_cnt <= wr_cnt + 1;
        end else rdata <= mem[mem_addr_o[9:2]];
      end
    end
  end

  // transmit sink with random latency and random error outcome
  logic [31:0] s_addr [0:63];
  logic [10:0] s_len  [0:63];
  logic        s_f [0:63], s_l [0:63], s_s [0:63], s_err [0:63];
  int          seg_n = 0, sdly = 0, ovf_cnt = 0, rdy_in_susp = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      tx_done = 0; tx_err = 0; sdly = 0;
    end else if (tx_done) tx_done = 0;
    else if (tx_seg_valid_o) begin
      if (sdly != 0) sdly--;
      else begin
        s_addr[seg_n] = tx_seg_addr_o; s_len[seg_n] = tx_seg_len_o;
        s_f[seg_n] = tx_seg_first_o; s_l[seg_n] = tx_seg_last_o;
        s_s[seg_n] = tx_seg_setup_o; s_err[seg_n] = 1'($urandom % 2);
        tx_err = s_err[seg_n]; tx_done = 1; seg_n++;
        sdly = $urandom % 4;
      end
    end
    if (rx_ovf_o) ovf_cnt++;
    if (rx_state_o == 2'd3 && rx_frm_ready_o) rdy_in_susp++;
  end

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_ctl [0:63], e_buf [0:63];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic host_wr(input int idx, input logic [31:0] v);
    @(negedge clk); h_we = 1; h_idx = 8'(idx); h_dat = v;
    @(negedge clk); h_we = 0;
  endtask

  // arm one transmit descriptor; status with ownership written last
  task automatic arm_tx(input int d, input int sn, input bit eor);
    logic [31:0] c, b;
    c = 32'($urandom_range(1, 2047));
    c[30] = 1'($urandom); c[29] = 1'($urandom); c[27] = 1'($urandom);
    c[26] = 1'($urandom); c[28] = 1'($urandom); c[25] = eor;
    b = $urandom & 32'hffff_fffc;
    e_ctl[sn] = c; e_buf[sn] = b;
    host_wr(4*d + 1, c); host_wr(4*d + 2, b); host_wr(4*d, 32'h8000_0000);
  endtask

  task automatic chk_segs(input int first, input int n);
    for (int k = first; k < first + n; k++) begin
      chk(s_addr[k] == e_buf[k], "R2 seg addr", s_addr[k], e_buf[k]);
      chk({s_f[k], s_l[k], s_s[k], s_len[k]} ==
          {e_ctl[k][29], e_ctl[k][30], e_ctl[k][27], e_ctl[k][10:0]},
          "R2 seg fields", {s_f[k], s_l[k], s_s[k], 5'd0, s_len[k]},
          {e_ctl[k][29], e_ctl[k][30], e_ctl[k][27], 5'd0, e_ctl[k][10:0]});
    end
  endtask

  task automatic send_frame(input logic [13:0] l, input bit e);
    @(negedge clk); rx_valid = 1; rx_len = l; rx_err = e;
    for (int k = 0; k < 4000 && !rx_frm_ready_o; k++) @(negedge clk);
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [13:0] l1, l2, l3;
    logic [31:0] rb0, rb1;
    int base_seg;
    bit quiet;
    void'($urandom(32'd20240611));
    rst_ni = 1'b1;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_state_o == 0 && rx_state_o == 0, "R1 states in reset", {tx_state_o, rx_state_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && !tx_seg_valid_o && !rx_frm_ready_o && tx_state_o == 0 && rx_state_o == 0,
        "R1 idle after reset", {mem_req_o, tx_seg_valid_o, rx_frm_ready_o, tx_state_o, rx_state_o}, 0);

    // R10: poll while stopped
    tx_poll = 1; @(negedge clk); tx_poll = 0;
    quiet = 1;
    for (int k = 0; k < 10; k++) begin
      if (mem_req_o || tx_state_o != 0) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R10 poll ignored when stopped", {31'd0, quiet}, 1);

    // first transmit pass, three descriptors, end of ring on the third
    for (int d = 0; d < 3; d++) arm_tx(d, d, d == 2);
    @(negedge clk); tx_run = 1;
    @(negedge clk);
    chk(mem_req_o && !mem_we_o && mem_addr_o == TXB, "R8 start fetches base", mem_addr_o, TXB);
    for (int k = 0; k < 2000 && !(seg_n == 3 && tx_state_o == 2); k++) @(negedge clk);
    chk(tx_state_o == 2, "R4 suspend on unowned", tx_state_o, 2);
    chk_segs(0, 3);
    for (int d = 0; d < 3; d++)
      chk(mem[4*d] == (s_err[d] ? 32'h8000 : 32'h0), "R3 tx status write", mem[4*d], s_err[d] ? 32'h8000 : 0);
    chk(wr_cnt == 3, "R3 one write per descriptor", wr_cnt, 3);
    quiet = 1;
    for (int k = 0; k < 20; k++) begin
      if (mem_req_o) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R4 no traffic while suspended", {31'd0, quiet}, 1);

    // random rounds: re-arm, poll, wrap back to base
    for (int r = 0; r < 5; r++) begin
      base_seg = 3 + 3*r;
      for (int d = 0; d < 3; d++) arm_tx(d, base_seg + d, d == 2);
      @(negedge clk); tx_poll = 1;
      @(negedge clk); tx_poll = 0;
      chk(mem_req_o && !mem_we_o && mem_addr_o == TXB, "R4 R5 poll re-reads wrapped desc", mem_addr_o, TXB);
      for (int k = 0; k < 2000 && !(seg_n == base_seg + 3 && tx_state_o == 2); k++) @(negedge clk);
      chk(seg_n == base_seg + 3, "R5 ring order", seg_n, base_seg + 3);
      chk_segs(base_seg, 3);
      for (int d = 0; d < 3; d++)
        chk(mem[4*d] == (s_err[base_seg+d] ? 32'h8000 : 32'h0), "R3 tx status write",
            mem[4*d], s_err[base_seg+d] ? 32'h8000 : 0);
    end

    // receive ring of two at word 64
    rb0 = $urandom & 32'hffff_fffc; rb1 = $urandom & 32'hffff_fffc;
    host_wr(65, 32'h0000_0600); host_wr(66, rb0); host_wr(64, 32'h8000_0000);
    host_wr(69, 32'h0200_0600); host_wr(70, rb1); host_wr(68, 32'h8000_0000);
    @(negedge clk); rx_run = 1;
    for (int k = 0; k < 200 && !rx_frm_ready_o; k++) @(negedge clk);
    chk(rx_frm_ready_o && rx_buf_addr_o == rb0, "R6 buffer offered", rx_buf_addr_o, rb0);
    l1 = 14'($urandom_range(64, 1518));
    send_frame(l1, 0);
    for (int k = 0; k < 200 && !rx_frm_ready_o; k++) @(negedge clk);
    chk(rx_buf_addr_o == rb1, "R5 rx advance by 16", rx_buf_addr_o, rb1);
    chk(mem[64] == ({18'd0, l1} << 16 | 32'h100), "R6 rx status good", mem[64], {18'd0, l1} << 16 | 32'h100);
    l2 = 14'($urandom_range(64, 1518));
    send_frame(l2, 1);
    for (int k = 0; k < 200 && rx_state_o != 3; k++) @(negedge clk);
    chk(mem[68] == ({18'd0, l2} << 16 | 32'h8100), "R6 rx status error", mem[68], {18'd0, l2} << 16 | 32'h8100);
    chk(rx_state_o == 3 && !rx_frm_ready_o, "R7 rx suspended", {rx_state_o, rx_frm_ready_o}, 3 << 1);

    // overflow: frame pending with no owned descriptor
    l3 = 14'($urandom_range(64, 1518));
    ovf_cnt = 0;
    fork send_frame(l3, 0); join_none
    repeat (30) @(negedge clk);
    chk(ovf_cnt > 0 && rx_valid && rdy_in_susp == 0, "R7 overflow flagged, frame held", ovf_cnt, 1);
    chk(tx_state_o == 2, "R8 tx unaffected by rx", tx_state_o, 2);
    host_wr(64, 32'h8000_0000);
    for (int k = 0; k < 400 && rx_valid; k++) @(negedge clk);
    for (int k = 0; k < 200 && rx_state_o != 3; k++) @(negedge clk);
    chk(mem[64] == ({18'd0, l3} << 16 | 32'h100), "R5 R7 rx wrap after refill", mem[64], {18'd0, l3} << 16 | 32'h100);

    // stop and restart transmit
    @(negedge clk); tx_run = 0;
    @(negedge clk);
    chk(tx_state_o == 0 && rx_state_o == 3, "R8 independent stop", {tx_state_o, rx_state_o}, 3);
    arm_tx(0, 18, 0);
    @(negedge clk); tx_run = 1;
    @(negedge clk);
    chk(mem_req_o && !mem_we_o && mem_addr_o == TXB, "R8 restart from base", mem_addr_o, TXB);
    for (int k = 0; k < 2000 && !(seg_n == 19 && tx_state_o == 2); k++) @(negedge clk);
    chk_segs(18, 1);
    repeat (5) @(negedge clk);
    chk(wr_cnt == 22, "R9 write count both engines", wr_cnt, 22);

    summary();
    $finish;
  end
endmodule